// File: doc/BRIEF.md
# Watchdog Timer with Tick Prescaler and APB Register Access

This block is a watchdog that a processor programs over an APB slave port. A programmable prescaler divides the block clock into a slow tick. On each tick the watchdog countdown drops by two. If software fails to reload the countdown in time, the countdown runs out and the block issues a one-cycle soft-reset request to the chip reset controller. Software can also force a request at once by setting a trigger bit.

Three external conditions can pause the countdown, each behind its own enable bit: processor 1 halted in debug, processor 0 halted in debug, and a JTAG master using the bus. A cause register records whether the last request came from expiry or from the trigger. Eight scratch words let software keep state across a soft reset. The block takes only the hardware reset, so the soft-reset request it raises never clears the scratch words or the cause register. One clock drives the whole block.

Top module: `wdog_apb_timer`

## Requirements
- R1: After hardware reset, offset 0x00 reads 0x07000000 (enable 0, pause bits 26..24 set, count 0), offset 0x2C reads 0x00000200 (tick enable set, cycles 0), and the cause register at 0x08 reads 0.
- R2: A write to offset 0x04 loads bits 23:0 into the countdown, which is visible in bits 23:0 of offset 0x00. Reads of 0x04 return 0.
- R3: On each tick with bit 30 of 0x00 set and no active pause, a countdown above 2 drops by exactly 2.
- R4: While bit 30 of 0x00 is 0, the countdown holds its value while ticks occur.
- R5: Bit 26 pauses the countdown while processor 1 is halted, bit 25 while processor 0 is halted, and bit 24 while JTAG is active. A halt whose pause bit is clear does not stop counting.
- R6: A counting tick with the countdown at 2 or less sets the countdown to 0, raises the soft-reset request for one cycle on the next edge, and sets the cause register to 0x1. A loaded value N gives the request max(1, ceil(N/2)) ticks after counting starts.
- R7: Writing 0x00 with bit 31 set raises the request on the write edge and sets the cause register to 0x2. Bit 31 always reads 0.
- R8: Scratch words at 0x0C + 4*k (k = 0..7) are 32-bit read/write. Only hardware reset clears them, and they keep their value after a request.
- R9: Offset 0x2C has cycles in bits 8:0, tick enable in bit 9, running in bit 10 and remaining count in bits 19:11. Running is tick enable with nonzero cycles. After the prescaler starts, the remaining count loads the cycles value on the next edge and then falls by one per cycle. A tick fires each time it reaches 1. When the prescaler is stopped, the remaining count is 0 and no tick fires.
- R10: Every APB transfer finishes with no wait state and no error response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the prescaler reference |
| rst_n | input | 1 | Active-low hardware reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | AW | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| halt_cpu0 | input | 1 | Processor 0 halted in debug |
| halt_cpu1 | input | 1 | Processor 1 halted in debug |
| jtag_busy | input | 1 | JTAG master is using the bus |
| soft_rst_req | output | 1 | One-cycle soft-reset request |

## Verification
Expiry timing is measured against the cycle count from the prescaler start, using an even load with one divider and an odd load with another. This separates a step of two from a step of one, and it also catches an off-by-one in the expiry threshold or in the reload of the prescaler. The pause inputs are moved one at a time between their own pause bit and a bit that does not cover them. Each pause must hold the countdown, while a halt whose pause bit is clear must leave it counting. A forced trigger, enable held low with ticks running, and a prescaler with zero cycles separate the two causes of a request, and they separate holding the countdown from stopping the tick.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_RELOAD = 8'h04;
  localparam logic [7:0] OFS_CAUSE  = 8'h08;
  localparam logic [7:0] OFS_SCR0   = 8'h0C;
  localparam logic [7:0] OFS_TICK   = 8'h2C;

  // countdown value after one counting tick, floored at zero
  function automatic logic [31:0] wd_step(logic [31:0] cur, int unsigned dec);
    return (cur <= dec) ? 32'd0 : cur - dec;
  endfunction

  // a counting tick at this value ends the countdown
  function automatic logic wd_runs_out(logic [31:0] cur, int unsigned dec);
    return cur <= dec;
  endfunction
endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
  parameter int PRE_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [PRE_W-1:0] period,
  output logic [PRE_W-1:0] remain,
  output logic             running,
  output logic             tick
);
  localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

  assign running = tick_en && (period != '0);
  assign tick    = running && (remain == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             remain <= '0;
    else if (!running)                      remain <= '0;
    else if (remain == '0 || remain == ONE) remain <= period;
    else                                    remain <= remain - ONE;
  end
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
  import wdog_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int DEC   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  assign expire = step && !load && wd_runs_out(32'(cnt), DEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (step) cnt <= CNT_W'(wd_step(32'(cnt), DEC));
  end
endmodule

// File: rtl/wdog_apb_timer.sv
module wdog_apb_timer
  import wdog_pkg::*;
#(
  parameter int AW    = 8,
  parameter int CNT_W = 24,
  parameter int PRE_W = 9,
  parameter int N_SCR = 8,
  parameter int DEC   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  output logic          pready,
  output logic          pslverr,
  input  logic          halt_cpu0,
  input  logic          halt_cpu1,
  input  logic          jtag_busy,
  output logic          soft_rst_req
);
  localparam int TK_EN  = PRE_W;
  localparam int TK_RUN = PRE_W + 1;
  localparam int TK_REM = PRE_W + 2;

  // control state
  logic             en_q;
  logic [2:0]       pause_q;   // [2] cpu1, [1] cpu0, [0] jtag
  logic             tick_en_q;
  logic [PRE_W-1:0] period_q;
  logic [1:0]       cause_q;   // [1] forced, [0] expired
  logic [31:0]      scr_q [N_SCR];

  // named internal events
  logic             wr_w, load_w, force_w, tick_w, running_w, paused_w, step_w, expire_w;
  logic [PRE_W-1:0] remain_w;
  logic [CNT_W-1:0] cnt_w;
  logic [N_SCR-1:0] scr_hit;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign wr_w    = psel && penable && pwrite;
  assign load_w  = wr_w && (8'(paddr) == OFS_RELOAD);
  assign force_w = wr_w && (8'(paddr) == OFS_CTRL) && pwdata[31];

  for (genvar g = 0; g < N_SCR; g++) begin : g_scr_dec
    assign scr_hit[g] = (8'(paddr) == OFS_SCR0 + 8'(4 * g));
  end

  assign paused_w = |(pause_q & {halt_cpu1, halt_cpu0, jtag_busy});
  assign step_w   = tick_w && en_q && !paused_w;

  wdog_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en_q), .period(period_q),
    .remain(remain_w), .running(running_w), .tick(tick_w)
  );

  wdog_countdown #(.CNT_W(CNT_W), .DEC(DEC)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load_w), .load_val(pwdata[CNT_W-1:0]),
    .step(step_w), .cnt(cnt_w), .expire(expire_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      pause_q   <= 3'b111;
      tick_en_q <= 1'b1;
      period_q  <= '0;
    end else if (wr_w) begin
      if (8'(paddr) == OFS_CTRL) begin
        en_q    <= pwdata[30];
        pause_q <= pwdata[26:24];
      end
      if (8'(paddr) == OFS_TICK) begin
        tick_en_q <= pwdata[TK_EN];
        period_q  <= pwdata[PRE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q      <= 2'b00;
      soft_rst_req <= 1'b0;
    end else begin
      soft_rst_req <= expire_w || force_w;
      if (expire_w || force_w) cause_q <= {force_w, expire_w};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SCR; i++) scr_q[i] <= '0;
    end else if (wr_w) begin
      for (int i = 0; i < N_SCR; i++) if (scr_hit[i]) scr_q[i] <= pwdata;
    end
  end

  always_comb begin
    prdata = '0;
    unique case (8'(paddr))
      OFS_CTRL:  prdata = {1'b0, en_q, 3'b000, pause_q, 24'(cnt_w)};
      OFS_CAUSE: prdata = {30'd0, cause_q};
      OFS_TICK: begin
        prdata[PRE_W-1:0]            = period_q;
        prdata[TK_EN]                = tick_en_q;
        prdata[TK_RUN]               = running_w;
        prdata[TK_REM +: PRE_W]      = remain_w;
      end
      default: begin
        for (int i = 0; i < N_SCR; i++) if (scr_hit[i]) prdata = scr_q[i];
      end
    endcase
  end
endmodule

// File: rtl/wdog_apb_timer_chk.sv
module wdog_apb_timer_chk #(
  parameter int CNT_W = 24,
  parameter int DEC   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pready,
  input logic             pslverr,
  input logic             req,
  input logic             tick,
  input logic             running,
  input logic             step,
  input logic             paused,
  input logic             load,
  input logic             expire,
  input logic             force_w,
  input logic [CNT_W-1:0] cnt,
  input logic [1:0]       cause
);
  p_step_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && 32'(cnt) > DEC) |=> (32'(cnt) == 32'($past(cnt)) - DEC));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(cnt));

  p_pause_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !step);

  p_expire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt == '0 && cause[0] && req));

  p_req_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> $past(expire || force_w));

  p_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
    force_w |=> (req && cause[1]));

  p_idle_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !tick);

  p_no_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pready && !pslverr);
endmodule

bind wdog_apb_timer wdog_apb_timer_chk #(.CNT_W(CNT_W), .DEC(DEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .pready(pready), .pslverr(pslverr),
  .req(soft_rst_req), .tick(tick_w), .running(running_w), .step(step_w),
  .paused(paused_w), .load(load_w), .expire(expire_w), .force_w(force_w),
  .cnt(cnt_w), .cause(cause_q)
);

// File: tb/test_wdog_apb_timer.sv
module test_wdog_apb_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, soft_rst_req;
  logic        halt_cpu0 = 1'b0, halt_cpu1 = 1'b0, jtag_busy = 1'b0;

  int          total = 0, bad = 0;
  int          cyc = 0;
  logic [31:0] last_rd;
  logic [31:0] q_exp[$];
  logic [31:0] q_mask[$];
  string       q_tag[$];
  int          q_req[$];
  int          wcyc;
  bit          done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_apb_timer i_wdog_apb_timer (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .halt_cpu0(halt_cpu0), .halt_cpu1(halt_cpu1),
    .jtag_busy(jtag_busy), .soft_rst_req(soft_rst_req)
  );

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // monitor: read data and request pulses
  always @(negedge clk) begin
    if (rst_n && psel && penable) begin
      check(pready && !pslverr, "R10 handshake", {30'd0, pslverr, pready}, 32'h1);
      if (!pwrite) begin
        last_rd = prdata;
        if (q_exp.size() > 0) begin
          logic [31:0] e, m;
          string t;
          e = q_exp.pop_front(); m = q_mask.pop_front(); t = q_tag.pop_front();
          check((prdata & m) == (e & m), t, prdata & m, e & m);
        end
      end
    end
    if (rst_n && soft_rst_req) begin
      if (q_req.size() == 0) check(1'b0, "R6/R7 unexpected request", 32'(cyc), 32'hFFFFFFFF);
      else begin
        int e;
        e = q_req.pop_front();
        check(cyc == e, "R6/R7 request cycle", 32'(cyc), 32'(e));
      end
    end
  end

  task automatic apb_wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(posedge clk); #1;
    penable = 1'b1;
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    wcyc = cyc;
  endtask

  task automatic apb_rd(logic [7:0] a, logic [31:0] e, logic [31:0] m, string t);
    q_exp.push_back(e); q_mask.push_back(m); q_tag.push_back(t);
    apb_peek(a);
  endtask

  task automatic apb_peek(logic [7:0] a);
    @(posedge clk); #1;
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(posedge clk); #1;
    penable = 1'b1;
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic wait_req();
    while (q_req.size() != 0) @(negedge clk);
  endtask

  function automatic int ticks_for(int n);
    int t;
    t = (n + 1) / 2;
    return (t < 1) ? 1 : t;
  endfunction

  // expiry run: load n, enable, start prescaler with c cycles
  task automatic expiry_run(int n, int c, string t);
    apb_wr(8'h04, 32'(n));
    apb_wr(8'h00, 32'h4000_0000);
    apb_wr(8'h2C, 32'h200 | 32'(c));
    q_req.push_back(wcyc + 1 + c * ticks_for(n));
    wait_req();
    apb_wr(8'h00, 32'h0);
    apb_wr(8'h2C, 32'h200);
    apb_rd(8'h08, 32'h1, 32'hFFFFFFFF, {t, " cause after expiry"});
    apb_rd(8'h00, 32'h0, 32'hFFFFFFFF, {t, " countdown floored"});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    apb_rd(8'h00, 32'h0700_0000, 32'hFFFFFFFF, "R1 control reset");
    apb_rd(8'h2C, 32'h0000_0200, 32'hFFFFFFFF, "R1 tick reset");
    apb_rd(8'h08, 32'h0, 32'hFFFFFFFF, "R1 cause reset");
    apb_rd(8'h0C, 32'h0, 32'hFFFFFFFF, "R8 scratch reset");

    // R8 scratch
    apb_wr(8'h0C, 32'hA5C3_0F1E);
    apb_wr(8'h28, 32'h1234_5678);
    apb_wr(8'h18, 32'hFFFF_0000);
    apb_rd(8'h0C, 32'hA5C3_0F1E, 32'hFFFFFFFF, "R8 scratch0");
    apb_rd(8'h28, 32'h1234_5678, 32'hFFFFFFFF, "R8 scratch7");
    apb_rd(8'h18, 32'hFFFF_0000, 32'hFFFFFFFF, "R8 scratch3");

    // R2 reload
    apb_wr(8'h04, 32'hFF12_3456);
    apb_rd(8'h00, 32'h0712_3456, 32'hFFFFFFFF, "R2 reload visible");
    apb_rd(8'h04, 32'h0, 32'hFFFFFFFF, "R2 reload reads zero");

    // R7 forced trigger
    apb_wr(8'h00, 32'h8700_0000);
    q_req.push_back(wcyc);
    wait_req();
    apb_rd(8'h00, 32'h0712_3456, 32'hFFFFFFFF, "R7 trigger reads zero");
    apb_rd(8'h08, 32'h2, 32'hFFFFFFFF, "R7 cause forced");

    // R9 zero cycles: no ticks, countdown holds
    apb_wr(8'h00, 32'h4000_0000);
    repeat (50) @(posedge clk);
    apb_rd(8'h00, 32'h4012_3456, 32'hFFFFFFFF, "R9 zero cycles no tick");
    apb_wr(8'h00, 32'h0);

    // R9 live remaining count and running flag
    apb_wr(8'h2C, 32'h207);
    apb_rd(8'h2C, 32'h0000_3607, 32'hFFFFFFFF, "R9 tick live count");
    apb_wr(8'h2C, 32'h007);
    apb_rd(8'h2C, 32'h0000_0007, 32'hFFFFFFFF, "R9 tick stopped");

    // R3 R6 expiry timing, even and odd load
    expiry_run(16, 6, "R3 R6 even");
    expiry_run(7, 7, "R3 R6 odd");
    apb_rd(8'h0C, 32'hA5C3_0F1E, 32'hFFFFFFFF, "R8 scratch kept after request");

    // R4 enable low holds with ticks running
    apb_wr(8'h04, 32'h100);
    apb_wr(8'h00, 32'h0700_0000);
    apb_wr(8'h2C, 32'h202);
    repeat (40) @(posedge clk);
    apb_rd(8'h00, 32'h0700_0100, 32'hFFFFFFFF, "R4 hold while disabled");

    // R5 each pause source
    halt_cpu0 = 1'b1;
    apb_wr(8'h00, 32'h4200_0000);
    repeat (40) @(posedge clk);
    apb_rd(8'h00, 32'h4200_0100, 32'hFFFFFFFF, "R5 pause cpu0");
    halt_cpu1 = 1'b1;
    apb_wr(8'h00, 32'h4400_0000);
    halt_cpu0 = 1'b0;
    repeat (40) @(posedge clk);
    apb_rd(8'h00, 32'h4400_0100, 32'hFFFFFFFF, "R5 pause cpu1");
    jtag_busy = 1'b1;
    apb_wr(8'h00, 32'h4100_0000);
    halt_cpu1 = 1'b0;
    repeat (40) @(posedge clk);
    apb_rd(8'h00, 32'h4100_0100, 32'hFFFFFFFF, "R5 pause jtag");
    apb_wr(8'h00, 32'h4600_0000);
    repeat (40) @(posedge clk);
    apb_peek(8'h00);
    begin
      logic [23:0] c;
      c = last_rd[23:0];
      check(c < 24'h100 && c > 24'h80, "R5 uncovered halt counts", 32'(c), 32'h100);
      check(((24'h100 - c) % 2) == 0, "R3 even step", 32'(c), 32'h100);
    end
    apb_wr(8'h00, 32'h0);
    apb_wr(8'h2C, 32'h200);
    jtag_busy = 1'b0;

    repeat (5) @(posedge clk);
    check(q_req.size() == 0 && q_exp.size() == 0, "R6 pending items", 32'(q_req.size()), 32'h0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'(cyc), 32'h0);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule